// File: doc/BRIEF.md
# Paged EEPROM Write Emulator

This block models a byte-wide nonvolatile memory that the host drives like a static RAM. The host uses active-low chip enable, output enable and write enable, a 13-bit address and an 8-bit data path. A read returns the stored byte. A write does not go to storage straight away. Each write strobe captures its address and data into a page latch of 64 entries, and the host buses are free once the byte is captured.

When no accepted strobe arrives for a parameterized window of cycles, the block starts a self-timed commit. The commit copies every loaded latch entry into the on-chip array, and a parameterized cycle count stands in for the programming time. While the commit runs, a read returns a polling status on data bit 7. That bit is the inverse of bit 7 of the last byte loaded. Once it reads back true, the commit is over and the host may start a new access.

The data path is split into an input `din`, an output `dout` and an output-enable flag `dout_en`, so a pad ring can build the bidirectional bus outside the block.

Top module: `eeprom_page_writer`

## Requirements
- R1: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1 all hold. With `oe_n`=1, or with `we_n`=0, it is 0.
- R2: When no commit is running, `dout` holds the stored byte at the address sampled on the previous rising clock edge (one cycle of read latency).
- R3: A write strobe is a clock edge at which `ce_n`=0 and `we_n`=0, while `we_n` was 1 at the edge before. Driving `we_n` low with `ce_n`=1 writes nothing.
- R4: The first strobe of an operation fixes the page to `addr[12:6]`. Strobes during loading whose `addr[12:6]` differ from that page are ignored and do not extend the load window.
- R5: The commit begins LOAD_WIN clock edges after the last accepted strobe. A read sampled one edge earlier still returns plain data, and each accepted strobe restarts the window.
- R6: The commit lasts PROG_CYCLES edges. A read sampled at edge PROG_CYCLES-1 of the commit still shows the polling form. The next read shows stored data.
- R7: During the commit, `dout` = {~b7, 7'b0}, where b7 is bit 7 of the last byte accepted. Both polarities of b7 are covered.
- R8: After the commit, each loaded offset (`addr[5:0]`) reads back the last byte loaded to it, including rewritten offsets.
- R9: Array bytes at page offsets that were not loaded keep their earlier contents through the commit.
- R10: Strobes during the commit change neither the page latch nor the array, and they do not start a new operation.
- R11: One operation can load any count from 1 to 64 bytes. A full 64-byte page and a single byte both commit correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its falling edge is the write strobe |
| addr | input | 13 | Byte address; bits 12..6 select the page, bits 5..0 the offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or polling status while a commit runs |
| dout_en | output | 1 | High when the host may drive its bus from `dout` |

## Verification
A read has one cycle of latency: the bench sets the address at a falling edge, and the monitor samples `dout` just after the next rising edge.

The bench counts rising edges from the edge that accepted the last strobe. It expects the polling form exactly when that count k satisfies LOAD_WIN <= k < LOAD_WIN+PROG_CYCLES. It places reads at k = LOAD_WIN-1, LOAD_WIN, LOAD_WIN+PROG_CYCLES-1 and LOAD_WIN+PROG_CYCLES, so that both edges of the commit are checked to the cycle.

Every other expected byte comes from a model memory that the bench updates only for the strobes it expects to be accepted.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_host_if.sv
module eep_host_if (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_stb,
  output logic out_en
);
  logic we_prev_q, we_prev_d;

  assign we_prev_d = we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_prev_q <= 1'b1;
    else        we_prev_q <= we_prev_d;
  end

  assign wr_stb = !ce_n && !we_n && we_prev_q;
  assign out_en = !ce_n && !oe_n && we_n;

  assert_stb_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ld_en,
  input  logic [PAGE_W-1:0] ld_off,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_d;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld_d[g] = clear ? 1'b0 :
                      (ld_en && ld_off == PAGE_W'(g)) ? 1'b1 : vld_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ld_en) data_q[ld_off] <= ld_data;
  end

  assign rd_data  = data_q[rd_off];
  assign rd_valid = vld_q[rd_off];

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld_q == '0));
  assert_no_clear_and_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && ld_en));
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int LOAD_WIN    = 15000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              page_hit,
  output logic              accept,
  output logic              first,
  output logic              busy,
  output logic              prog_act,
  output logic [PAGE_W-1:0] prog_idx,
  output logic              commit_done
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int WC_W       = $clog2(LOAD_WIN + 1);
  localparam int PC_W       = $clog2(PROG_CYCLES + 1);
  localparam logic [WC_W-1:0] WIN_LAST  = WC_W'(LOAD_WIN - 1);
  localparam logic [PC_W-1:0] PROG_LAST = PC_W'(PROG_CYCLES - 1);
  localparam logic [PC_W-1:0] PAGE_LIM  = PC_W'(PAGE_BYTES);

  eep_state_e      st_q, st_d;
  logic [WC_W-1:0] win_q, win_d;
  logic [PC_W-1:0] pc_q, pc_d;

  assign first  = wr_stb && (st_q == ST_IDLE);
  assign accept = first || (wr_stb && (st_q == ST_LOAD) && page_hit);

  always_comb begin
    st_d  = st_q;
    win_d = win_q;
    pc_d  = pc_q;
    case (st_q)
      ST_IDLE: begin
        if (first) begin
          st_d  = ST_LOAD;
          win_d = '0;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          win_d = '0;
        end else if (win_q == WIN_LAST) begin
          st_d = ST_COMMIT;
          pc_d = '0;
        end else begin
          win_d = win_q + WC_W'(1);
        end
      end
      ST_COMMIT: begin
        if (pc_q == PROG_LAST) st_d = ST_IDLE;
        else                   pc_d = pc_q + PC_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      win_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      pc_q  <= pc_d;
    end
  end

  assign busy        = (st_q == ST_COMMIT);
  assign prog_act    = busy && (pc_q < PAGE_LIM);
  assign prog_idx    = pc_q[PAGE_W-1:0];
  assign commit_done = busy && (pc_q == PROG_LAST);

  assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |-> (win_q < WC_W'(LOAD_WIN)));
  assert_commit_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(st_q) == ST_LOAD));
  assert_prog_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc_q < PC_W'(PROG_CYCLES)));
  assert_commit_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (st_q == ST_IDLE));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q, rd_d;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_d = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 6,
  parameter int LOAD_WIN    = 15000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              wr_stb, out_en;
  logic              accept, first, busy, prog_act, commit_done;
  logic [PAGE_W-1:0] prog_idx;
  logic [DATA_W-1:0] lat_data, arr_rdata;
  logic              lat_valid, arr_we, page_hit;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              b7_q, b7_d;

  eep_host_if u_host (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_stb(wr_stb), .out_en(out_en)
  );

  assign page_hit = (addr[ADDR_W-1:PAGE_W] == row_q);

  eep_seq #(.PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .page_hit(page_hit),
    .accept(accept), .first(first), .busy(busy), .prog_act(prog_act),
    .prog_idx(prog_idx), .commit_done(commit_done)
  );

  eep_page_latch #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear(commit_done), .ld_en(accept),
    .ld_off(addr[PAGE_W-1:0]), .ld_data(din), .rd_off(prog_idx),
    .rd_data(lat_data), .rd_valid(lat_valid)
  );

  assign arr_we = prog_act && lat_valid;

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr({row_q, prog_idx}),
    .wdata(lat_data), .raddr(addr), .rdata(arr_rdata)
  );

  assign row_d = first  ? addr[ADDR_W-1:PAGE_W] : row_q;
  assign b7_d  = accept ? din[DATA_W-1]         : b7_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      b7_q  <= 1'b0;
    end else begin
      row_q <= row_d;
      b7_q  <= b7_d;
    end
  end

  assign dout    = busy ? {~b7_q, {(DATA_W-1){1'b0}}} : arr_rdata;
  assign dout_en = out_en;

  assert_array_write_in_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  assert_latch_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(row_q) && $stable(b7_q)));
  assert_poll_inverts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dout[DATA_W-1] != b7_q));
  assert_drive_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || ce_n || !we_n) |-> !dout_en);
endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int LW   = 8;
  localparam int PROG = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int strobe_cyc = -1000000;
  logic last_b7 = 1'b0;
  logic chk_on = 1'b0;
  logic [7:0] mdl [8192];

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t exp_q[$];
  item_t cur;

  eeprom_page_writer #(.LOAD_WIN(LW), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (chk_on) begin
      #1;
      cur = exp_q.pop_front();
      check(cur.req, dout, cur.exp);
      check("R1", {7'b0, dout_en}, 8'h01);
    end
  end

  function automatic logic [12:0] pa(input int row, input int off);
    return 13'((row << 6) | off);
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit acc, input bit use_ce);
    ce_n = !use_ce; we_n = 1'b0; addr = a; din = d;
    if (acc) begin
      mdl[a] = d;
      last_b7 = d[7];
      strobe_cyc = cyc + 1;
    end
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, input string req);
    int k;
    item_t it;
    k = cyc + 1 - strobe_cyc;
    it.exp = (k >= LW && k < LW + PROG) ? {~last_b7, 7'b0} : mdl[a];
    it.req = req;
    exp_q.push_back(it);
    ce_n = 1'b0; oe_n = 1'b0; addr = a; chk_on = 1'b1;
    @(negedge clk);
    chk_on = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_k(input int kt);
    while ((cyc + 1 - strobe_cyc) < kt) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: drive gate with oe_n high, and with we_n low while chip disabled
    check("R1", {7'b0, dout_en}, 8'h00);
    oe_n = 1'b0; we_n = 1'b0;
    #1 check("R1", {7'b0, dout_en}, 8'h00);
    oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);

    // Op A: full page at row 9 (R11)
    for (int i = 0; i < 64; i++) wr(pa(9, i), 8'(8'h40 + i), 1'b1, 1'b1);
    wait_k(LW + 5);
    rd(pa(9, 0), "R7");
    wait_k(LW + PROG);
    rd(pa(9, 0), "R11");
    rd(pa(9, 63), "R11");
    rd(pa(9, 30), "R2");

    // Op B: full page at row 5, last byte has bit 7 set
    for (int i = 0; i < 64; i++) wr(pa(5, i), 8'(i * 7 + 3), 1'b1, 1'b1);
    wait_k(LW + PROG);
    rd(pa(5, 10), "R2");
    rd(pa(5, 63), "R2");

    // Op C: partial load at row 9 with stray and rewritten strobes
    wr(pa(9, 0), 8'h11, 1'b1, 1'b1);
    wr(pa(5, 2), 8'h99, 1'b0, 1'b1);   // R4: other page, ignored
    wr(pa(9, 5), 8'h22, 1'b1, 1'b1);
    wr(pa(9, 5), 8'h2A, 1'b1, 1'b1);
    wr(pa(9, 63), 8'h3C, 1'b1, 1'b1);
    wait_k(LW - 1);
    rd(pa(5, 10), "R5");               // last edge before commit: data
    rd(pa(5, 10), "R5");               // first commit edge: polling 0x80
    wr(pa(9, 7), 8'hEE, 1'b0, 1'b1);   // R10: ignored during commit
    wr(pa(5, 1), 8'hEE, 1'b0, 1'b1);   // R10
    wait_k(LW + PROG - 1);
    rd(pa(5, 3), "R6");                // last commit edge: polling
    rd(pa(5, 3), "R6");                // after commit: data
    rd(pa(9, 0), "R8");
    rd(pa(9, 5), "R8");
    rd(pa(9, 63), "R8");
    rd(pa(9, 7), "R9");
    rd(pa(9, 8), "R9");
    rd(pa(9, 7), "R10");
    rd(pa(5, 1), "R10");
    rd(pa(5, 2), "R4");

    // Op D: single byte with bit 7 set
    wr(pa(3, 17), 8'hA5, 1'b1, 1'b1);
    wait_k(LW + 1);
    rd(pa(3, 17), "R7");               // polling 0x00
    wait_k(LW + PROG);
    rd(pa(3, 17), "R11");
    rd(pa(3, 17), "R8");

    // Op E: we_n low with chip disabled writes nothing
    wr(pa(5, 4), 8'h00, 1'b0, 1'b0);
    repeat (LW + 20) @(negedge clk);
    rd(pa(5, 4), "R3");
    rd(pa(9, 6), "R2");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule